// File: doc/BRIEF.md
# Wiper Setting Store Sequencer

This block sits behind a serial control port that adjusts a bank of wiper (potentiometer tap) settings. It keeps one storage byte per wiper in a small array that stands in for nonvolatile cells. Each storage byte is loaded into the wipers when the block leaves reset, and again whenever the chip select is low. While chip select is high, a frame on the serial data line moves one wiper to a new value. That change is temporary. At the same time the frame shifts the previous value out of the readback pin.

A frame becomes permanent only when the host raises the program request inside a narrow window around the end of the frame and the supply is reported good. The block then runs an erase/write interval, counted in serial clock rising edges, and holds its ready output low for that interval. At the end of the interval it writes the byte into the addressed storage entry and bumps a commit counter. The interval only advances while the serial clock runs.

The controller is a single state machine with these states:
- LOAD: copies storage into the wipers after reset, then moves to IDLE.
- IDLE: waits for a start bit and moves to SHIFT.
- SHIFT: collects the address and data bits. After the last bit it moves to TAIL1.
- TAIL1: waits for the next rising edge and moves to TAIL2.
- TAIL2: at the next falling edge it makes the store decision and moves either to BUSY or to GAP.
- GAP: a start bit here goes straight to SHIFT. Any other rising edge moves to IDLE.
- BUSY: counts the interval and returns to IDLE at commit.

Chip select low returns SHIFT, TAIL1, TAIL2 and GAP to IDLE. BUSY ignores chip select.

Top module: `pv_store_seq`

## Requirements
- R1: After reset is released, with the serial clock held still, the wiper outputs hold the storage contents within two clock cycles. Storage starts as FACTORY_BASE + i*FACTORY_STEP for entry i, so the defaults are 0x10, 0x30, 0x50 and 0x70. After reset, ready is 1, store_count is 0 and do_en is 0 while cs is low.
- R2: A frame is sent with cs high and is sampled on rising sclk edges. It is a start bit of 1, then address bit 0, then address bit 1 (entry = 2*bit1 + bit0), then data bits D0 to D7, least significant first. Wiper entry i sits at wiper_out[8i+7:8i]. Once the D7 edge has been taken, the addressed wiper shows the new byte.
- R3: do_en is high while cs is high and the block is not busy. From the rising edge that takes address bit 1 until the D7 edge, do_bit shows the addressed wiper's previous value, LSB first, with one new bit after each rising edge.
- R4: While cs is low, every wiper shows its storage byte, one clock cycle behind. Dropping cs in the middle of a frame abandons it, and nothing is stored.
- R5: A store is requested only when prog rises after the start bit has been taken and is still high at the first falling sclk edge after the rising edge that follows D7. A prog that was already high before the start bit does not request a store. Neither does a prog that rises after that falling edge.
- R6: After an accepted request, ready goes low at the decision edge. It stays low, even with sclk stopped, until PROG_CYCLES rising sclk edges have been counted. At that edge the byte is written into the addressed entry, store_count increases by one and ready returns high.
- R7: While ready is low, do_en is 0 and frames on di have no effect on the wipers or on storage.
- R8: If low_supply is high at the decision edge, ready stays high, nothing is written and store_count does not change.
- R9: A frame without a store request leaves storage unchanged. Its byte is gone once cs goes low.
- R10: A start bit on the second rising edge after D7 begins a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, samples all other inputs |
| rst_n | input | 1 | Active-low power-on reset |
| sclk | input | 1 | Serial clock level |
| cs | input | 1 | Chip select, high to talk to the block |
| di | input | 1 | Serial data in |
| prog | input | 1 | Program (store) request |
| low_supply | input | 1 | High when supply is too low to program |
| wiper_out | output | NUM_CH*DATA_W | Current wiper settings, entry i at bits [8i+7:8i] |
| do_bit | output | 1 | Serial readback data |
| do_en | output | 1 | Readback driver enable (low means high impedance) |
| ready | output | 1 | High when ready, low during the write interval |
| store_count | output | CNT_W | Number of committed stores |

## Verification
A wrong storage byte stays hidden until cs goes low. One clock after that it shows on wiper_out, so every scenario ends with a cs-low compare of all four entries. A bad bit index or a bad window state shows within the same frame: it either corrupts the readback on do_bit or moves ready at the wrong sclk edge. A bad busy counter shows as ready rising one edge early or late. The bench therefore samples ready both one edge before and exactly at the expected release.

// File: rtl/pv_store_pkg.sv
package pv_store_pkg;
    typedef enum logic [2:0] {
        ST_LOAD,
        ST_IDLE,
        ST_SHIFT,
        ST_TAIL1,
        ST_TAIL2,
        ST_GAP,
        ST_BUSY
    } seq_state_t;
endpackage

// File: rtl/pv_level_reg.sv
// Registers a group of input levels so edges can be found one clock later.
module pv_level_reg #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] lvl_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl;
    end
endmodule

// File: rtl/pv_store_array.sv
// Storage entries standing in for nonvolatile cells; reset gives factory content.
module pv_store_array #(
    parameter int NUM_CH        = 4,
    parameter int DATA_W        = 8,
    parameter int FACTORY_BASE  = 16,
    parameter int FACTORY_STEP  = 32,
    localparam int ADDR_W       = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     commit,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        data,
    output logic [NUM_CH*DATA_W-1:0] stored
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ent
        localparam logic [DATA_W-1:0] INIT = DATA_W'(FACTORY_BASE + i * FACTORY_STEP);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                stored[i*DATA_W +: DATA_W] <= INIT;
            else if (commit && addr == ADDR_W'(i))
                stored[i*DATA_W +: DATA_W] <= data;
        end
    end
endmodule

// File: rtl/pv_wiper_bank.sv
// Live wiper registers: bulk reload from storage or single-entry update.
module pv_wiper_bank #(
    parameter int NUM_CH  = 4,
    parameter int DATA_W  = 8,
    localparam int ADDR_W = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reload,
    input  logic [NUM_CH*DATA_W-1:0] stored,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    output logic [NUM_CH*DATA_W-1:0] wiper
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_wip
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                wiper[i*DATA_W +: DATA_W] <= '0;
            else if (reload)
                wiper[i*DATA_W +: DATA_W] <= stored[i*DATA_W +: DATA_W];
            else if (wr_en && wr_addr == ADDR_W'(i))
                wiper[i*DATA_W +: DATA_W] <= wr_data;
        end
    end
endmodule

// File: rtl/pv_store_seq.sv
module pv_store_seq
    import pv_store_pkg::*;
#(
    parameter int NUM_CH       = 4,
    parameter int DATA_W       = 8,
    parameter int PROG_CYCLES  = 4000,
    parameter int CNT_W        = 16,
    parameter int FACTORY_BASE = 16,
    parameter int FACTORY_STEP = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sclk,
    input  logic                     cs,
    input  logic                     di,
    input  logic                     prog,
    input  logic                     low_supply,
    output logic [NUM_CH*DATA_W-1:0] wiper_out,
    output logic                     do_bit,
    output logic                     do_en,
    output logic                     ready,
    output logic [CNT_W-1:0]         store_count
);
    localparam int ADDR_W     = $clog2(NUM_CH);
    localparam int FRAME_BITS = ADDR_W + DATA_W;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int BUSY_W     = $clog2(PROG_CYCLES + 1);

    seq_state_t state, state_nx;

    logic [1:0] lvl_q;
    logic sclk_rise, sclk_fall, prog_rise;

    logic [IDX_W-1:0]      bit_idx;
    logic [FRAME_BITS-1:0] frame_sr, frame_nx;
    logic [ADDR_W-1:0]     pend_addr, rd_addr;
    logic [DATA_W-1:0]     pend_data, dout_sr, rd_word;
    logic                  data_phase, armed;
    logic [BUSY_W-1:0]     busy_cnt;
    logic [NUM_CH*DATA_W-1:0] stored_flat;

    logic start_seen, addr_done, last_bit, go_store, busy_done, in_frame, frame_nx_st;

    pv_level_reg #(.N(2)) u_lvl (
        .clk(clk), .rst_n(rst_n), .lvl({prog, sclk}), .lvl_q(lvl_q)
    );

    assign sclk_rise = sclk & ~lvl_q[0];
    assign sclk_fall = ~sclk & lvl_q[0];
    assign prog_rise = prog & ~lvl_q[1];

    assign frame_nx   = {di, frame_sr[FRAME_BITS-1:1]};
    assign rd_addr    = frame_nx[FRAME_BITS-1 -: ADDR_W];
    assign start_seen = sclk_rise && cs && di;
    assign addr_done  = sclk_rise && state == ST_SHIFT && bit_idx == IDX_W'(ADDR_W - 1);
    assign last_bit   = sclk_rise && state == ST_SHIFT && bit_idx == IDX_W'(FRAME_BITS - 1);
    assign go_store   = sclk_fall && state == ST_TAIL2 && armed && prog && !low_supply;
    assign busy_done  = sclk_rise && state == ST_BUSY && busy_cnt == BUSY_W'(PROG_CYCLES - 1);
    assign in_frame   = state inside {ST_SHIFT, ST_TAIL1, ST_TAIL2};
    assign frame_nx_st = state_nx inside {ST_SHIFT, ST_TAIL1, ST_TAIL2};

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (rd_addr == ADDR_W'(i)) rd_word = wiper_out[i*DATA_W +: DATA_W];
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LOAD:  state_nx = ST_IDLE;
            ST_IDLE:  if (start_seen) state_nx = ST_SHIFT;
            ST_SHIFT: if (!cs) state_nx = ST_IDLE;
                      else if (last_bit) state_nx = ST_TAIL1;
            ST_TAIL1: if (!cs) state_nx = ST_IDLE;
                      else if (sclk_rise) state_nx = ST_TAIL2;
            ST_TAIL2: if (!cs) state_nx = ST_IDLE;
                      else if (go_store) state_nx = ST_BUSY;
                      else if (sclk_fall) state_nx = ST_GAP;
            ST_GAP:   if (!cs) state_nx = ST_IDLE;
                      else if (start_seen) state_nx = ST_SHIFT;
                      else if (sclk_rise) state_nx = ST_IDLE;
            ST_BUSY:  if (busy_done) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_LOAD;
        else        state <= state_nx;
    end

    // frame and interval datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx     <= '0;
            frame_sr    <= '0;
            pend_addr   <= '0;
            pend_data   <= '0;
            dout_sr     <= '0;
            data_phase  <= 1'b0;
            armed       <= 1'b0;
            busy_cnt    <= '0;
            store_count <= '0;
        end else begin
            if (state inside {ST_IDLE, ST_GAP} && start_seen)
                bit_idx <= '0;
            else if (state == ST_SHIFT && sclk_rise)
                bit_idx <= bit_idx + 1'b1;

            if (state == ST_SHIFT && sclk_rise)
                frame_sr <= frame_nx;

            if (last_bit) begin
                pend_addr <= frame_nx[ADDR_W-1:0];
                pend_data <= frame_nx[FRAME_BITS-1:ADDR_W];
            end

            if (addr_done)
                dout_sr <= rd_word;
            else if (state == ST_SHIFT && sclk_rise && data_phase)
                dout_sr <= dout_sr >> 1;

            data_phase <= (state_nx == ST_SHIFT) && (addr_done || data_phase) && !last_bit;
            armed      <= frame_nx_st && (armed || (prog_rise && in_frame));

            if (state != ST_BUSY)  busy_cnt <= '0;
            else if (sclk_rise)    busy_cnt <= busy_cnt + 1'b1;

            if (busy_done) store_count <= store_count + 1'b1;
        end
    end

    // outputs
    always_comb begin
        ready  = (state != ST_BUSY);
        do_en  = cs && state != ST_BUSY && state != ST_LOAD;
        do_bit = do_en && data_phase && dout_sr[0];
    end

    pv_store_array #(
        .NUM_CH(NUM_CH), .DATA_W(DATA_W),
        .FACTORY_BASE(FACTORY_BASE), .FACTORY_STEP(FACTORY_STEP)
    ) u_arr (
        .clk(clk), .rst_n(rst_n), .commit(busy_done),
        .addr(pend_addr), .data(pend_data), .stored(stored_flat)
    );

    pv_wiper_bank #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_wip (
        .clk(clk), .rst_n(rst_n),
        .reload(!cs || state == ST_LOAD), .stored(stored_flat),
        .wr_en(last_bit && cs), .wr_addr(frame_nx[ADDR_W-1:0]),
        .wr_data(frame_nx[FRAME_BITS-1:ADDR_W]), .wiper(wiper_out)
    );
endmodule

// File: rtl/pv_store_seq_chk.sv
module pv_store_seq_chk #(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cs,
    input logic                     ready,
    input logic                     do_en,
    input logic                     low_supply,
    input logic [CNT_W-1:0]         store_count,
    input logic [NUM_CH*DATA_W-1:0] wiper_out,
    input logic [NUM_CH*DATA_W-1:0] stored_flat
);
    AST_BUSY_NO_DO: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !do_en); // R7

    AST_LOW_SUPPLY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> $past(!low_supply)); // R8

    AST_COMMIT_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (store_count != $past(store_count)) |-> $rose(ready)); // R6

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (store_count != $past(store_count)) |-> (store_count == $past(store_count) + 1'b1)); // R6

    AST_DESELECT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!cs)) |-> (wiper_out == $past(stored_flat))); // R4
endmodule

bind pv_store_seq pv_store_seq_chk #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cs(cs), .ready(ready), .do_en(do_en),
    .low_supply(low_supply), .store_count(store_count),
    .wiper_out(wiper_out), .stored_flat(stored_flat)
);

// File: tb/sim_pv_store_seq.sv
module sim_pv_store_seq;
    localparam int PC = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, cs = 1'b0, di = 1'b0, prog = 1'b0, low_supply = 1'b0;
    logic [31:0] wiper_out;
    logic do_bit, do_en, ready;
    logic [15:0] store_count;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [7:0] mem [4];
    int commits = 0;

    always #4 clk = ~clk;

    pv_store_seq #(.PROG_CYCLES(PC)) u0 (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs(cs), .di(di), .prog(prog),
        .low_supply(low_supply), .wiper_out(wiper_out), .do_bit(do_bit),
        .do_en(do_en), .ready(ready), .store_count(store_count)
    );

    // vector: {addr[1:0], data[7:0], prog, low_supply}
    localparam logic [11:0] VEC [8] = '{
        {2'd0, 8'hA5, 1'b1, 1'b0},
        {2'd3, 8'h3C, 1'b0, 1'b0},
        {2'd1, 8'hFF, 1'b1, 1'b1},
        {2'd2, 8'h00, 1'b1, 1'b0},
        {2'd1, 8'h5A, 1'b1, 1'b0},
        {2'd3, 8'h81, 1'b1, 1'b0},
        {2'd0, 8'h11, 1'b0, 1'b0},
        {2'd2, 8'hC3, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic d, output logic q);
        @(negedge clk) di = d;
        repeat (2) @(negedge clk);
        sclk = 1'b1;
        repeat (3) @(negedge clk);
        q = do_bit;
        sclk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic tick(input logic d);
        logic q;
        pulse(d, q);
    endtask

    task automatic send_frame(input logic [1:0] a, input logic [7:0] d,
                              input bit raise_prog, output logic [7:0] rd);
        logic q;
        @(negedge clk) cs = 1'b1;
        tick(1'b1);
        tick(a[0]);
        pulse(a[1], q);
        rd[0] = q;
        for (int i = 0; i < 8; i++) begin
            if (raise_prog && i == 3) prog = 1'b1;
            pulse(d[i], q);
            if (i < 7) rd[i+1] = q;
        end
    endtask

    task automatic check_stored(input string req);
        @(negedge clk) cs = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 4; i++)
            chk(req, {24'h0, wiper_out[i*8 +: 8]}, {24'h0, mem[i]});
        chk(req, store_count, commits);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        for (int i = 0; i < 4; i++) mem[i] = 8'(8'h10 + i * 8'h20);

        // R1: power-on load without sclk activity
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 4; i++)
            chk("R1 factory wiper", {24'h0, wiper_out[i*8 +: 8]}, {24'h0, mem[i]});
        chk("R1 ready", ready, 1);
        chk("R1 count", store_count, 0);
        chk("R1 do_en off", do_en, 0);

        // R3: readback driver on when selected
        @(negedge clk) cs = 1'b1;
        repeat (3) @(negedge clk);
        chk("R3 do_en selected", do_en, 1);
        @(negedge clk) cs = 1'b0;
        repeat (3) @(negedge clk);

        // vector table
        for (int v = 0; v < 8; v++) begin
            logic [1:0] a;
            logic [7:0] d;
            logic p, lo;
            {a, d, p, lo} = VEC[v];
            low_supply = lo;
            send_frame(a, d, p, rd);
            chk("R3 readback", rd, mem[a]);
            chk("R2 temp wiper", wiper_out[a*8 +: 8], d);
            tick(1'b0);                      // rise after D7, then decision fall
            if (p && !lo) begin
                chk("R6 busy low", ready, 0);
                chk("R7 do_en busy", do_en, 0);
                prog = 1'b0;
                for (int k = 0; k < PC - 1; k++) tick(1'b0);
                chk("R6 still busy", ready, 0);
                tick(1'b0);
                chk("R6 released", ready, 1);
                commits++;
                mem[a] = d;
                chk("R6 count", store_count, commits);
            end else begin
                chk(lo ? "R8 ready high" : "R9 ready high", ready, 1);
                prog = 1'b0;
                tick(1'b0);
            end
            low_supply = 1'b0;
            check_stored(lo ? "R8 not stored" : (p ? "R6 stored" : "R9 discarded"));
        end

        // R5: prog raised after the decision edge
        send_frame(2'd2, 8'h77, 1'b0, rd);
        tick(1'b0);
        @(negedge clk) prog = 1'b1;
        tick(1'b0);
        chk("R5 late prog", ready, 1);
        prog = 1'b0;
        check_stored("R5 late prog storage");

        // R5: prog already high before the start bit
        @(negedge clk) prog = 1'b1;
        send_frame(2'd1, 8'h66, 1'b0, rd);
        tick(1'b0);
        chk("R5 early prog", ready, 1);
        prog = 1'b0;
        tick(1'b0);
        check_stored("R5 early prog storage");

        // R10: next frame starts on second rise after D7
        send_frame(2'd1, 8'hAA, 1'b0, rd);
        tick(1'b0);
        send_frame(2'd2, 8'h42, 1'b0, rd);
        chk("R10 back-to-back readback", rd, mem[2]);
        chk("R10 back-to-back wiper", wiper_out[2*8 +: 8], 8'h42);
        chk("R10 first frame wiper", wiper_out[1*8 +: 8], 8'hAA);
        check_stored("R10 storage");

        // R6/R7: stopped clock holds busy, frames ignored during busy
        send_frame(2'd3, 8'h99, 1'b1, rd);
        tick(1'b0);
        prog = 1'b0;
        chk("R6 busy entered", ready, 0);
        repeat (40) @(negedge clk);
        chk("R6 stopped sclk stays busy", ready, 0);
        chk("R7 do_en busy", do_en, 0);
        tick(1'b1); tick(1'b0); tick(1'b0);
        tick(1'b0); tick(1'b1);
        chk("R7 still busy", ready, 0);
        tick(1'b1);
        chk("R6 released after stop", ready, 1);
        chk("R7 wiper 0 untouched", wiper_out[7:0], mem[0]);
        commits++;
        mem[3] = 8'h99;
        check_stored("R6 stored after stop");

        // R4: cs drop mid-frame abandons it
        @(negedge clk) cs = 1'b1;
        tick(1'b1); tick(1'b0); tick(1'b0);
        @(negedge clk) prog = 1'b1;
        tick(1'b1); tick(1'b1);
        @(negedge clk) cs = 1'b0;
        repeat (3) @(negedge clk);
        prog = 1'b0;
        chk("R4 abort ready", ready, 1);
        check_stored("R4 abort storage");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule